// File: doc/BRIEF.md
# Interrupt Vector Target Fetch Unit

This unit works out where the core goes after an interrupt has been taken. For a non-vectored interrupt it picks a shared entry address from one of two base registers, one cycle after the request. For a vectored interrupt it reads the handler address from a table in memory and then jumps to that address. The table holds one 32-bit word per interrupt source, and the entry sits at the table base plus four times the interrupt ID. The read can come back with an error. In that case the unit reports an instruction access fault in place of the jump.

The same table read also serves the "jump to next pending interrupt" CSR access. If an interrupt is pending, that access jumps to the pending interrupt's handler. It also writes the PC of the access into the link register and sets the global interrupt enable. If no interrupt is pending, the access does nothing. Every table-based jump or fault also pulses a fetch-done strobe, which lets the CSR unit clear its in-progress flag.

Only one table read can be outstanding. While a read is outstanding, the ready output is low and new requests are ignored.

Top module: `irq_vec_fetch`

## Requirements
- R1: After reset, `accept_rdy` is 1, and `jump_valid`, `fault_valid`, `fetch_done`, `link_we`, `mie_set` and `mem_req_valid` are all 0.
- R2: A non-vectored take (`take_valid`=1, `take_vectored`=0) accepted while `alt_base[0]`=0 gives a one-cycle `jump_valid` in the next cycle. `jump_target` is `exc_base` with bits [1:0] forced to 0, and `fetch_done` stays 0.
- R3: A non-vectored take accepted while `alt_base[0]`=1 gives the same one-cycle jump, but `jump_target` is `alt_base` with bits [1:0] forced to 0.
- R4: A vectored take with ID n issues exactly one one-cycle `mem_req_valid` at address `tbl_base + 4*n`. In the cycle after an error-free response, `jump_valid` and `fetch_done` pulse together, and `jump_target` equals `mem_rsp_data`.
- R5: A table read answered with `mem_rsp_err`=1 gives a one-cycle `fault_valid` and `fetch_done` in the cycle after the response. No jump, link write or enable-set follows.
- R6: A chain access (`chain_valid`=1, `chain_pending`=1) reads the table entry of `chain_id`. On an error-free response it pulses `jump_valid` to the word read, together with `link_we` (with `link_data` = `chain_pc`), `mie_set` and `fetch_done`.
- R7: A chain access with `chain_pending`=0 causes no memory request and no output strobe, and leaves `accept_rdy` at 1.
- R8: From the accept of a table read until its response, `accept_rdy` is 0 and any take or chain request is ignored. At most one request is outstanding.
- R9: When a take and a chain access are presented in the same accepted cycle, the take is served and the chain access is dropped.
- R10: `jump_valid` and `fault_valid` are never 1 together. `link_we` and `mie_set` are only 1 together with a table-based `jump_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_valid | input | 1 | An interrupt has been taken |
| take_vectored | input | 1 | The taken interrupt is vectored |
| take_id | input | ID_W | ID of the taken interrupt |
| chain_valid | input | 1 | Next-pending-interrupt CSR access |
| chain_pending | input | 1 | An interrupt is pending for the chain access |
| chain_id | input | ID_W | ID of the pending interrupt |
| chain_pc | input | XLEN | PC of the chain access instruction |
| tbl_base | input | XLEN | Vector table base address |
| exc_base | input | XLEN | Exception base register |
| alt_base | input | XLEN | Second base register; bit 0 selects it as the non-vectored entry |
| accept_rdy | output | 1 | Unit can accept a request this cycle |
| mem_req_valid | output | 1 | Table read request (one cycle) |
| mem_req_addr | output | XLEN | Table read address |
| mem_rsp_valid | input | 1 | Table read response |
| mem_rsp_data | input | XLEN | Word read from the table |
| mem_rsp_err | input | 1 | Table read failed |
| jump_valid | output | 1 | Jump target is valid (one cycle) |
| jump_target | output | XLEN | Jump target address |
| fault_valid | output | 1 | Instruction access fault on the table read |
| fetch_done | output | 1 | Table-based jump or fault has completed |
| link_we | output | 1 | Write link register |
| link_data | output | XLEN | Value for the link register |
| mie_set | output | 1 | Set the global interrupt enable |

## Verification
The assertions rely on the memory side returning exactly one response per request, and never in the same cycle as the request itself. They also rely on all request inputs being low while reset is asserted. The bench's memory model follows these rules: it answers only after it has seen `mem_req_valid`, with a latency of at least one cycle, and it sends one response per request. The bench also drives all inputs to 0 before it releases reset. Requests made while the unit is busy are deliberately outside the accepted window. They are handled by the design ignoring them, so they do not violate the assumptions.

// File: rtl/ivf_pkg.sv
// ivf_pkg: shared types and constants of the interrupt vector target fetch unit.
// Assumes table words are 32 bits wide, so an entry is 4 bytes.
package ivf_pkg;

    // log2 of the byte size of one vector table word
    localparam int unsigned WORD_SHIFT = 2;

    // sequencer state: idle, issuing the table read, awaiting its response
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    // context captured when a table read is accepted
    typedef struct packed {
        logic is_chain;
    } rd_ctx_t;

endpackage

// File: rtl/ivf_entry_sel.sv
// ivf_entry_sel: picks the shared entry address for non-vectored interrupts.
// When bit 0 of the second base register is set, that register supplies the
// entry; otherwise the exception base does. The two low bits are always dropped.
// Assumes XLEN > WORD_SHIFT.
module ivf_entry_sel #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] exc_base,
    input  logic [XLEN-1:0] alt_base,
    output logic [XLEN-1:0] nv_entry
);
    import ivf_pkg::*;

    localparam int unsigned HI = XLEN - WORD_SHIFT;

    logic [XLEN-1:0] chosen;

    // choose between the two base registers
    always_comb begin
        chosen = alt_base[0] ? alt_base : exc_base;
    end

    // clear the low alignment bits
    always_comb begin
        nv_entry = {chosen[XLEN-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
    end

    initial begin
        if (HI == 0) $error("ivf_entry_sel: XLEN too small");
    end
endmodule

// File: rtl/ivf_addr_calc.sv
// ivf_addr_calc: forms the vector table entry address base + ID * word size.
// Assumes ID_W + WORD_SHIFT <= XLEN.
module ivf_addr_calc #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned ID_W = 12
) (
    input  logic [XLEN-1:0] tbl_base,
    input  logic [ID_W-1:0] irq_id,
    output logic [XLEN-1:0] entry_addr
);
    import ivf_pkg::*;

    localparam int unsigned PAD = XLEN - ID_W - WORD_SHIFT;

    logic [XLEN-1:0] offset;

    // scale the ID to a byte offset
    always_comb begin
        offset = {{PAD{1'b0}}, irq_id, {WORD_SHIFT{1'b0}}};
    end

    // add the offset to the table base
    always_comb begin
        entry_addr = tbl_base + offset;
    end
endmodule

// File: rtl/ivf_seq.sv
// ivf_seq: request acceptance, single outstanding table read, and registered
// result strobes. A take request has priority over a chain request. Assumes the
// memory returns one response per request, never in the request cycle.
module ivf_seq #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_valid,
    input  logic            take_vectored,
    input  logic            chain_valid,
    input  logic            chain_pending,
    input  logic [XLEN-1:0] chain_pc,
    input  logic [XLEN-1:0] nv_entry,
    input  logic [XLEN-1:0] tbl_addr,
    output logic            accept_rdy,
    output logic            mem_req_valid,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            jump_valid,
    output logic [XLEN-1:0] jump_target,
    output logic            fault_valid,
    output logic            fetch_done,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            mie_set
);
    import ivf_pkg::*;

    seq_state_t      state_q;
    rd_ctx_t         ctx_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] pc_q;
    logic            go_nv;
    logic            go_tbl;
    logic            go_chain;
    logic            rsp_hit;

    // decode which request is accepted this cycle
    always_comb begin
        accept_rdy = (state_q == ST_IDLE);
        go_nv      = accept_rdy && take_valid && !take_vectored;
        go_chain   = accept_rdy && !take_valid && chain_valid && chain_pending;
        go_tbl     = (accept_rdy && take_valid && take_vectored) || go_chain;
        rsp_hit    = (state_q == ST_WAIT) && mem_rsp_valid;
    end

    // sequencer state transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go_tbl) state_q <= ST_REQ;
                ST_REQ:  state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // capture the read address and chain context on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q         <= '0;
            pc_q           <= '0;
            ctx_q.is_chain <= 1'b0;
        end else if (go_tbl) begin
            addr_q         <= tbl_addr;
            pc_q           <= chain_pc;
            ctx_q.is_chain <= go_chain;
        end
    end

    // table read request is driven for the single REQ cycle
    always_comb begin
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = addr_q;
    end

    // registered one-cycle result strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_valid  <= 1'b0;
            fault_valid <= 1'b0;
            fetch_done  <= 1'b0;
            link_we     <= 1'b0;
            mie_set     <= 1'b0;
        end else begin
            jump_valid  <= go_nv || (rsp_hit && !mem_rsp_err);
            fault_valid <= rsp_hit && mem_rsp_err;
            fetch_done  <= rsp_hit;
            link_we     <= rsp_hit && !mem_rsp_err && ctx_q.is_chain;
            mie_set     <= rsp_hit && !mem_rsp_err && ctx_q.is_chain;
        end
    end

    // registered target and link value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_target <= '0;
            link_data   <= '0;
        end else if (go_nv) begin
            jump_target <= nv_entry;
        end else if (rsp_hit && !mem_rsp_err) begin
            jump_target <= mem_rsp_data;
            link_data   <= pc_q;
        end
    end
endmodule

// File: rtl/irq_vec_fetch.sv
// irq_vec_fetch: top of the interrupt vector target fetch unit. Forms the
// non-vectored entry, the table entry address of the selected ID (take wins
// over chain), and runs the read-then-jump sequence.
module irq_vec_fetch #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned ID_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_valid,
    input  logic            take_vectored,
    input  logic [ID_W-1:0] take_id,
    input  logic            chain_valid,
    input  logic            chain_pending,
    input  logic [ID_W-1:0] chain_id,
    input  logic [XLEN-1:0] chain_pc,
    input  logic [XLEN-1:0] tbl_base,
    input  logic [XLEN-1:0] exc_base,
    input  logic [XLEN-1:0] alt_base,
    output logic            accept_rdy,
    output logic            mem_req_valid,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            jump_valid,
    output logic [XLEN-1:0] jump_target,
    output logic            fault_valid,
    output logic            fetch_done,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            mie_set
);
    logic [ID_W-1:0] sel_id;
    logic [XLEN-1:0] nv_entry;
    logic [XLEN-1:0] tbl_addr;

    // the take request owns the ID when both are present
    always_comb begin
        sel_id = take_valid ? take_id : chain_id;
    end

    ivf_entry_sel #(.XLEN(XLEN)) entry_sel_i (
        .exc_base (exc_base),
        .alt_base (alt_base),
        .nv_entry (nv_entry)
    );

    ivf_addr_calc #(.XLEN(XLEN), .ID_W(ID_W)) addr_calc_i (
        .tbl_base   (tbl_base),
        .irq_id     (sel_id),
        .entry_addr (tbl_addr)
    );

    ivf_seq #(.XLEN(XLEN)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_valid    (take_valid),
        .take_vectored (take_vectored),
        .chain_valid   (chain_valid),
        .chain_pending (chain_pending),
        .chain_pc      (chain_pc),
        .nv_entry      (nv_entry),
        .tbl_addr      (tbl_addr),
        .accept_rdy    (accept_rdy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .jump_valid    (jump_valid),
        .jump_target   (jump_target),
        .fault_valid   (fault_valid),
        .fetch_done    (fetch_done),
        .link_we       (link_we),
        .link_data     (link_data),
        .mie_set       (mie_set)
    );
endmodule

// File: rtl/irq_vec_fetch_chk.sv
// irq_vec_fetch_chk: temporal checks on the ports of irq_vec_fetch.
// Assumes one memory response per request, never in the request cycle.
module irq_vec_fetch_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned ID_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_valid,
    input logic            take_vectored,
    input logic [ID_W-1:0] take_id,
    input logic            chain_valid,
    input logic            chain_pending,
    input logic [ID_W-1:0] chain_id,
    input logic [XLEN-1:0] chain_pc,
    input logic [XLEN-1:0] tbl_base,
    input logic [XLEN-1:0] exc_base,
    input logic [XLEN-1:0] alt_base,
    input logic            accept_rdy,
    input logic            mem_req_valid,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic [XLEN-1:0] mem_rsp_data,
    input logic            mem_rsp_err,
    input logic            jump_valid,
    input logic [XLEN-1:0] jump_target,
    input logic            fault_valid,
    input logic            fetch_done,
    input logic            link_we,
    input logic [XLEN-1:0] link_data,
    input logic            mie_set
);
    // non-vectored accept leads to a jump without fetch-done
    p_nv_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rdy && take_valid && !take_vectored) |=> (jump_valid && !fetch_done));

    // fetch-done only follows a memory response
    p_done_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> $past(mem_rsp_valid));

    // a fault only follows an erroneous response
    p_fault_after_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(mem_rsp_valid && mem_rsp_err));

    // chain access without a pending interrupt is a no-op
    p_chain_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rdy && !take_valid && chain_valid && !chain_pending)
        |=> (accept_rdy && !mem_req_valid && !jump_valid && !fault_valid));

    // the request lasts one cycle and the unit stays busy after it
    p_req_then_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> (!mem_req_valid && !accept_rdy));

    // the unit becomes ready again after the response
    p_ready_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_rdy && !mem_req_valid && mem_rsp_valid) |=> accept_rdy);

    // jump and fault are exclusive
    p_jump_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(jump_valid && fault_valid));

    // link write and enable-set only with a table-based jump
    p_link_with_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we || mie_set) |-> (jump_valid && fetch_done && link_we && mie_set));
endmodule

bind irq_vec_fetch irq_vec_fetch_chk #(.XLEN(XLEN), .ID_W(ID_W)) chk_i (.*);

// File: tb/irq_vec_fetch_tb_top.sv
// Scoreboard bench for irq_vec_fetch: driver tasks queue expected results,
// a monitor compares them with the outputs, and a memory model answers reads.
module irq_vec_fetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int ID_W = 12;
    localparam int WD_CYCLES = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            take_valid = 1'b0;
    logic            take_vectored = 1'b0;
    logic [ID_W-1:0] take_id = '0;
    logic            chain_valid = 1'b0;
    logic            chain_pending = 1'b0;
    logic [ID_W-1:0] chain_id = '0;
    logic [XLEN-1:0] chain_pc = '0;
    logic [XLEN-1:0] tbl_base = '0;
    logic [XLEN-1:0] exc_base = '0;
    logic [XLEN-1:0] alt_base = '0;
    logic            accept_rdy;
    logic            mem_req_valid;
    logic [XLEN-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [XLEN-1:0] mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            jump_valid;
    logic [XLEN-1:0] jump_target;
    logic            fault_valid;
    logic            fetch_done;
    logic            link_we;
    logic [XLEN-1:0] link_data;
    logic            mie_set;

    typedef struct {
        bit          is_fault;
        logic [31:0] target;
        bit          link;
        logic [31:0] link_val;
        bit          done;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    string       addr_tag_q[$];
    int          n_checks = 0;
    int          n_fails = 0;
    int          ev_count = 0;
    int          req_count = 0;
    int          rsp_lat = 1;
    bit          err_next = 1'b0;
    int          rsp_wait = 0;
    logic [31:0] rsp_addr = '0;
    bit          rsp_err_l = 1'b0;
    bit          finished = 1'b0;
    exp_t        cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_fetch #(.XLEN(XLEN), .ID_W(ID_W)) dut_i (.*);

    // word stored in the modelled vector table at a given address
    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        return (a * 32'd7) ^ 32'h1000_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // memory model: capture a request, answer after rsp_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (rsp_wait > 0) begin
                rsp_wait--;
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_err   = rsp_err_l;
                    mem_rsp_data  = tbl_word(rsp_addr);
                end
            end
            if (rst_n && mem_req_valid) begin
                req_count++;
                rsp_addr  = mem_req_addr;
                rsp_err_l = err_next;
                rsp_wait  = rsp_lat;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected table read", mem_req_addr, 32'h0);
                end else begin
                    check(mem_req_addr == addr_q[0], addr_tag_q[0], "table read address",
                          mem_req_addr, addr_q[0]);
                    void'(addr_q.pop_front());
                    void'(addr_tag_q.pop_front());
                end
            end
        end
    end

    // monitor: compare each result strobe with the queued expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (jump_valid || fault_valid) begin
                ev_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected output event",
                          {30'd0, jump_valid, fault_valid}, 32'd0);
                end else begin
                    cur = exp_q.pop_front();
                    check((fault_valid == cur.is_fault) && (jump_valid == !cur.is_fault)
                          && !(jump_valid && fault_valid), cur.tag, "jump/fault kind (R10)",
                          {30'd0, jump_valid, fault_valid}, {30'd0, !cur.is_fault, cur.is_fault});
                    if (!cur.is_fault)
                        check(jump_target == cur.target, cur.tag, "jump target",
                              jump_target, cur.target);
                    check(link_we == cur.link && mie_set == cur.link, cur.tag,
                          "link write / enable set", {30'd0, link_we, mie_set},
                          {30'd0, cur.link, cur.link});
                    if (cur.link)
                        check(link_data == cur.link_val, cur.tag, "link data",
                              link_data, cur.link_val);
                    check(fetch_done == cur.done, cur.tag, "fetch done",
                          {31'd0, fetch_done}, {31'd0, cur.done});
                end
            end else if (link_we || mie_set || fetch_done) begin
                check(1'b0, "R10", "strobe without jump or fault",
                      {29'd0, link_we, mie_set, fetch_done}, 32'd0);
            end
        end
    end

    task automatic push_exp(input bit f, input logic [31:0] t, input bit l,
                            input logic [31:0] lv, input bit d, input string tag);
        exp_t e;
        e.is_fault = f; e.target = t; e.link = l; e.link_val = lv; e.done = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_addr(input logic [31:0] a, input string tag);
        addr_q.push_back(a);
        addr_tag_q.push_back(tag);
    endtask

    task automatic drive_take(input bit vec, input logic [ID_W-1:0] id);
        @(negedge clk);
        take_valid = 1'b1; take_vectored = vec; take_id = id;
        @(negedge clk);
        take_valid = 1'b0; take_vectored = 1'b0;
    endtask

    task automatic drive_chain(input bit pend, input logic [ID_W-1:0] id,
                               input logic [31:0] pc);
        @(negedge clk);
        chain_valid = 1'b1; chain_pending = pend; chain_id = id; chain_pc = pc;
        @(negedge clk);
        chain_valid = 1'b0; chain_pending = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !accept_rdy || rsp_wait != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // main sequence
    initial begin
        int ev0;
        int rq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(accept_rdy == 1'b1, "R1", "accept_rdy after reset", {31'd0, accept_rdy}, 32'd1);
        check({jump_valid, fault_valid, fetch_done, link_we, mie_set, mem_req_valid} == 6'd0,
              "R1", "strobes after reset",
              {26'd0, jump_valid, fault_valid, fetch_done, link_we, mie_set, mem_req_valid}, 32'd0);

        tbl_base = 32'h1000_0000;
        exc_base = 32'h8000_0103;
        alt_base = 32'h2000_0046;

        // R2: non-vectored from exception base, low bits cleared
        push_exp(1'b0, 32'h8000_0100, 1'b0, 32'h0, 1'b0, "R2");
        drive_take(1'b0, 12'd3);
        drain();

        // R3: non-vectored from second base when its bit 0 is set
        alt_base = 32'h2000_0047;
        push_exp(1'b0, 32'h2000_0044, 1'b0, 32'h0, 1'b0, "R3");
        drive_take(1'b0, 12'd3);
        drain();
        alt_base = 32'h2000_0046;

        // R4: vectored, latency 1
        rsp_lat = 1; err_next = 1'b0;
        push_addr(32'h1000_0014, "R4");
        push_exp(1'b0, tbl_word(32'h1000_0014), 1'b0, 32'h0, 1'b1, "R4");
        drive_take(1'b1, 12'd5);
        drain();

        // R4: vectored, highest ID, latency 3
        rsp_lat = 3;
        push_addr(32'h1000_3FFC, "R4");
        push_exp(1'b0, tbl_word(32'h1000_3FFC), 1'b0, 32'h0, 1'b1, "R4");
        drive_take(1'b1, 12'hFFF);
        drain();

        // R5: vectored read error gives a fault
        rsp_lat = 2; err_next = 1'b1;
        push_addr(32'h1000_0020, "R5");
        push_exp(1'b1, 32'h0, 1'b0, 32'h0, 1'b1, "R5");
        drive_take(1'b1, 12'd8);
        drain();
        err_next = 1'b0;

        // R6: chain access with a pending interrupt
        rsp_lat = 1;
        push_addr(32'h1000_0024, "R6");
        push_exp(1'b0, tbl_word(32'h1000_0024), 1'b1, 32'h0000_4444, 1'b1, "R6");
        drive_chain(1'b1, 12'd9, 32'h0000_4444);
        drain();

        // R5/R6: chain access with read error: fault, no link
        err_next = 1'b1;
        push_addr(32'h1000_0040, "R5");
        push_exp(1'b1, 32'h0, 1'b0, 32'h0, 1'b1, "R5");
        drive_chain(1'b1, 12'd16, 32'h0000_5550);
        drain();
        err_next = 1'b0;

        // R7: chain access with nothing pending is a no-op
        ev0 = ev_count; rq0 = req_count;
        drive_chain(1'b0, 12'd2, 32'h0000_6660);
        repeat (4) @(negedge clk);
        check(ev_count == ev0 && req_count == rq0, "R7", "events/reads after no-op chain",
              ev_count - ev0 + req_count - rq0, 32'd0);
        check(accept_rdy == 1'b1, "R7", "accept_rdy after no-op chain", {31'd0, accept_rdy}, 32'd1);

        // R8: requests while a read is outstanding are ignored
        rsp_lat = 5;
        ev0 = ev_count;
        push_addr(32'h1000_0004, "R8");
        push_exp(1'b0, tbl_word(32'h1000_0004), 1'b0, 32'h0, 1'b1, "R8");
        drive_take(1'b1, 12'd1);
        check(accept_rdy == 1'b0, "R8", "accept_rdy while read outstanding",
              {31'd0, accept_rdy}, 32'd0);
        drive_take(1'b0, 12'd7);
        drive_chain(1'b1, 12'd6, 32'h0000_7770);
        drain();
        check(ev_count == ev0 + 1, "R8", "events for busy window", ev_count - ev0, 32'd1);

        // R9: take and chain together, take wins
        rsp_lat = 1;
        ev0 = ev_count; rq0 = req_count;
        push_exp(1'b0, 32'h8000_0100, 1'b0, 32'h0, 1'b0, "R9");
        @(negedge clk);
        take_valid = 1'b1; take_vectored = 1'b0; take_id = 12'd4;
        chain_valid = 1'b1; chain_pending = 1'b1; chain_id = 12'd10; chain_pc = 32'h0000_8880;
        @(negedge clk);
        take_valid = 1'b0; chain_valid = 1'b0; chain_pending = 1'b0;
        drain();
        check(req_count == rq0 && ev_count == ev0 + 1, "R9", "dropped chain access",
              req_count - rq0, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule